// File: doc/BRIEF.md
# Erase Pin Hold-Time Qualifier

This block decides whether a level on a dedicated flash-erase pin is a real erase request. The raw pin is brought into the slow-clock domain through a synchronizer chain. A counter then measures how many consecutive slow-clock samples see the pin high. A short high episode is rejected. An episode that lasts up to the long limit produces exactly one single-cycle erase command. The pin must go low before another command can be produced. The flash erase operation itself lies outside this block.

The pin can be reassigned as a general-purpose I/O. In that mode its level is masked, so it can never cause an erase, including while it is driven low as an output. After reset the pin has its erase function. A start-up sample input preloads the synchronizer while reset is asserted, so a pin that is already high when reset is released counts toward an erase from the first active clock edge.

The limits come from millisecond values and the slow-clock frequency. With 32768 Hz, the 100 ms limit is 3277 cycles and the 220 ms limit is 7209 cycles. A hold time between the two limits is resolved the same way every time: the command fires once the long limit is reached.

Top module: `erase_hold_qual`

## Requirements
- R1: While reset is asserted, and afterwards while the pin stays low, `erase_req` is 0.
- R2: A high episode shorter than SHORT_LIM (3277) consecutive samples never raises `erase_req`.
- R3: A high episode of LONG_LIM (7209) consecutive samples raises `erase_req` for exactly one cycle. The first rising edge that samples the pin high is edge 1. The pulse appears after edge LONG_LIM+2: two edges of synchronizer latency, then LONG_LIM edges of counting. An episode of LONG_LIM-1 samples raises nothing.
- R4: A single low sample inside an episode restarts the count from zero.
- R5: An episode held far beyond LONG_LIM yields only one pulse. A new pulse requires the pin to return low and then qualify again.
- R6: While `io_mode` is 1 (general I/O), the pin level is ignored and no pulse is raised. Returning `io_mode` to 0 restarts the count from zero.
- R7: With `boot_level` = 1 during reset and the pin held high, the pulse appears after edge LONG_LIM, counting edge 1 as the first edge after reset release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_slow | input | 1 | Slow clock, about 32 kHz |
| rst_n | input | 1 | Active-low reset, sampled on clk_slow |
| pin_raw | input | 1 | Asynchronous erase pin level |
| io_mode | input | 1 | 1 = pin used as general I/O, 0 = erase function |
| boot_level | input | 1 | Pin level loaded into the synchronizer during reset |
| erase_req | output | 1 | Single-cycle flash erase command |

## Verification
Four properties are checked on every cycle:
- a pulse never lasts more than one cycle;
- a pulse only appears with the counter at the long limit;
- general-I/O mode always blocks the next cycle's pulse;
- any low qualified level clears the counter.

Only the directed scenarios can show the hold-time behaviour. These scenarios cover:
- the exact edge on which the pulse lands;
- rejection one sample below the long limit and below the short limit;
- the restart after a single low sample;
- the single pulse on a very long hold;
- the start-up preload path.

// File: rtl/ehq_pkg.sv
package ehq_pkg;
   // Rounds up so that a limit in cycles is never shorter than the time asked for.
   function automatic int unsigned ehq_ms_to_cycles(input int unsigned ms, input int unsigned hz);
      return (ms * hz + 999) / 1000;
   endfunction
endpackage

// File: rtl/ehq_sync.sv
module ehq_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_async,
   input  logic preset,
   output logic q_sync
);
   logic [STAGES-1:0] chain;

   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
               if (!rst_n) chain[0] <= preset;
               else        chain[0] <= d_async;
            end
         end else begin : g_next
            always_ff @(posedge clk) begin
               if (!rst_n) chain[i] <= preset;
               else        chain[i] <= chain[i-1];
            end
         end
      end
   endgenerate

   assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/ehq_hold_cnt.sv
module ehq_hold_cnt #(
   parameter int unsigned LIMIT = 7209,
   localparam int unsigned CW   = $clog2(LIMIT + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          level,
   output logic [CW-1:0] count,
   output logic          fire
);
   localparam logic [CW-1:0] LIM_V = CW'(LIMIT);
   localparam logic [CW-1:0] PRE_V = CW'(LIMIT - 1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count <= '0;
         fire  <= 1'b0;
      end else begin
         fire <= level && (count == PRE_V);
         if (!level)              count <= '0;
         else if (count != LIM_V) count <= count + 1'b1;
      end
   end
endmodule

// File: rtl/erase_hold_qual.sv
module erase_hold_qual #(
   parameter int unsigned SLOW_HZ     = 32768,
   parameter int unsigned SHORT_MS    = 100,
   parameter int unsigned LONG_MS     = 220,
   parameter int unsigned SYNC_STAGES = 2,
   localparam int unsigned SHORT_LIM  = ehq_pkg::ehq_ms_to_cycles(SHORT_MS, SLOW_HZ),
   localparam int unsigned LONG_LIM   = ehq_pkg::ehq_ms_to_cycles(LONG_MS, SLOW_HZ),
   localparam int unsigned CNT_W      = $clog2(LONG_LIM + 1)
) (
   input  logic clk_slow,
   input  logic rst_n,
   input  logic pin_raw,
   input  logic io_mode,
   input  logic boot_level,
   output logic erase_req
);
   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("erase_hold_qual: SYNC_STAGES must be at least 2");
      end
      if (LONG_LIM <= SHORT_LIM) begin : g_bad_lim
         $error("erase_hold_qual: long limit must exceed short limit");
      end
   endgenerate

   logic             pin_sync;
   logic             lvl_q;
   logic [CNT_W-1:0] hold_cnt;

   ehq_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk_slow),
      .rst_n   (rst_n),
      .d_async (pin_raw),
      .preset  (boot_level),
      .q_sync  (pin_sync)
   );

   // General-I/O mode masks the pin, so the counter sees a low level.
   assign lvl_q = pin_sync & ~io_mode;

   ehq_hold_cnt #(.LIMIT(LONG_LIM)) u_cnt (
      .clk   (clk_slow),
      .rst_n (rst_n),
      .level (lvl_q),
      .count (hold_cnt),
      .fire  (erase_req)
   );
endmodule

// File: rtl/ehq_checker.sv
module ehq_checker #(
   parameter int unsigned LONG_LIM = 7209,
   localparam int unsigned CW      = $clog2(LONG_LIM + 1)
) (
   input logic          clk,
   input logic          rst_n,
   input logic          io_mode,
   input logic          lvl,
   input logic [CW-1:0] cnt,
   input logic          erase_req
);
   AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      erase_req |=> !erase_req);                                        // R5
   AST_PULSE_AT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      erase_req |-> (cnt == CW'(LONG_LIM)));                            // R3
   AST_GPIO_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      io_mode |=> !erase_req);                                          // R6
   AST_LOW_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      !lvl |=> (cnt == '0));                                            // R4
endmodule

bind erase_hold_qual ehq_checker #(.LONG_LIM(LONG_LIM)) u_chk (
   .clk       (clk_slow),
   .rst_n     (rst_n),
   .io_mode   (io_mode),
   .lvl       (lvl_q),
   .cnt       (hold_cnt),
   .erase_req (erase_req)
);

// File: tb/sim_erase_hold_qual.sv
module sim_erase_hold_qual;
   localparam int CLK_PERIOD = 10;
   localparam int SHORT = 3277;
   localparam int LONG  = 7209;

   logic clk = 0, rst_n = 0, pin = 0, io_mode = 0, boot = 0;
   wire  req;
   int   tests = 0, fails = 0, cyc = 0, pulses = 0, last_cyc = -1;

   erase_hold_qual u0 (.clk_slow(clk), .rst_n(rst_n), .pin_raw(pin), .io_mode(io_mode),
                       .boot_level(boot), .erase_req(req));

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;
   always @(negedge clk) if (req) begin pulses <= pulses + 1; last_cyc <= cyc; end

   task automatic check(input string rq, input int act, input int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
      end
   endtask

   task automatic idle(input int n);
      pin = 0; repeat (n) @(negedge clk);
   endtask

   task automatic hold_high(input int n);
      pin = 1; repeat (n) @(negedge clk); pin = 0;
   endtask

   task automatic t_reset();
      rst_n = 0; boot = 0; pin = 0;
      repeat (4) @(negedge clk);
      check("R1 during reset", req, 0);
      rst_n = 1; idle(20);
      check("R1 after reset", pulses, 0);
   endtask

   task automatic t_short();
      int p0 = pulses;
      hold_high(100);      idle(10);
      check("R2 100 samples", pulses - p0, 0);
      hold_high(SHORT - 1); idle(10);
      check("R2 SHORT-1 samples", pulses - p0, 0);
   endtask

   task automatic t_exact();
      int p0 = pulses, c0;
      hold_high(LONG - 1); idle(10);
      check("R3 LONG-1 samples rejected", pulses - p0, 0);
      c0 = cyc; hold_high(LONG); idle(10);
      check("R3 LONG samples one pulse", pulses - p0, 1);
      check("R3 pulse edge", last_cyc, c0 + LONG + 2);
   endtask

   task automatic t_restart();
      int p0 = pulses;
      hold_high(LONG - 1); idle(1); hold_high(LONG - 1); idle(10);
      check("R4 glitch restarts count", pulses - p0, 0);
   endtask

   task automatic t_long_hold();
      int p0 = pulses, c0;
      hold_high(2 * LONG + 50); idle(5);
      check("R5 long hold single pulse", pulses - p0, 1);
      c0 = cyc; hold_high(LONG); idle(10);
      check("R5 second episode pulses", pulses - p0, 2);
      check("R5 second pulse edge", last_cyc, c0 + LONG + 2);
   endtask

   task automatic t_gpio();
      int p0 = pulses, c0;
      io_mode = 1; hold_high(LONG + 200); idle(10);
      check("R6 gpio ignores pin", pulses - p0, 0);
      pin = 1; repeat (LONG - 10) @(negedge clk);
      io_mode = 0; c0 = cyc;
      repeat (20) @(negedge clk);
      check("R6 mode switch restarts count", pulses - p0, 0);
      repeat (LONG) @(negedge clk); pin = 0; idle(10);
      check("R6 erase after restart", pulses - p0, 1);
      check("R6 pulse edge", last_cyc, c0 + LONG);
   endtask

   task automatic t_boot();
      int p0, c0;
      rst_n = 0; boot = 1; pin = 1;
      repeat (3) @(negedge clk);
      p0 = pulses; rst_n = 1; c0 = cyc;
      repeat (LONG + 5) @(negedge clk);
      pin = 0; boot = 0; idle(10);
      check("R7 boot high counted", pulses - p0, 1);
      check("R7 pulse edge", last_cyc, c0 + LONG);
   endtask

   initial begin
      fork
         begin
            t_reset(); t_short(); t_exact(); t_restart();
            t_long_hold(); t_gpio(); t_boot();
         end
         begin
            repeat (200000) @(posedge clk);
            tests++; fails++;
            $display("FAIL watchdog actual=timeout expected=done");
         end
      join_any
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule